// File: doc/BRIEF.md
# Interrupt, Test and Reset Input Unit

This unit sits between the asynchronous control pins of a small processor core and its sequencer. Each pin (reset, wait-test, maskable request, non-maskable request) first passes through a chain of flops clocked on the rising clock edge. The raw reset is then filtered by a state machine: it becomes the core's internal reset only after its synchronized level has stayed high for a minimum number of consecutive clocks. The internal reset stays high until the pin falls. Shorter pulses are discarded.

A second state machine serves the sequencer. A rising edge on the non-maskable pin is stored in a pending flag. When the sequencer marks the last clock of an instruction, the unit decides whether the core must enter an interrupt sequence. A pending non-maskable request is served first, with the fixed vector type 2. Otherwise the maskable level request is served if the software enable flag is set, and the unit raises an acknowledge request so that the bus logic fetches the vector type in an external acknowledge cycle. While the core executes a wait instruction, the unit holds the core stalled for as long as the synchronized test input is high.

Reset-filter states: `RQ_IDLE` (pin low), `RQ_COUNT` (counting high samples), `RQ_HOLD` (internal reset driven). Transitions: IDLE→COUNT on a high sample; COUNT→IDLE on a low sample; COUNT→HOLD on the fourth consecutive high sample; HOLD→IDLE on a low sample. Arbiter states: `ARB_RUN` (normal execution), `ARB_WAIT` (stalled wait instruction), `ARB_NMI` (non-maskable take, one cycle), `ARB_INT` (maskable take, one cycle). Transitions: RUN→NMI on a boundary with a request pending; RUN→INT on a boundary with the request high and the enable flag set; RUN→WAIT when a wait instruction meets a high test level; WAIT→RUN when test goes low or the wait instruction ends; NMI→RUN and INT→RUN always. The internal reset forces RUN.

Top module: `irq_ctl_unit`

## Requirements
- R1: `core_rst_o` rises only after the synchronized reset has been sampled high on 4 consecutive clocks (MIN_RST); a raw reset pulse of 3 or fewer clocks never asserts it.
- R2: `core_rst_o` stays high while the reset pin stays high, and is low again within a few clocks of the pin returning low.
- R3: A low-to-high transition on `nmi_i` is latched. At the next clock where `boundary_i` is sampled high, the following cycle shows `take_o`=1, `ack_req_o`=0, `vec_o`=2.
- R4: The non-maskable request is served whatever the value of `ie_i`.
- R5: When `boundary_i` is sampled high, no non-maskable request is pending, the synchronized `intr_i` is high and `ie_i`=1, the following cycle shows `take_o`=1, `ack_req_o`=1, `vec_o`=0.
- R6: With `ie_i`=0, a high `intr_i` at a boundary produces no take: `take_o` and `ack_req_o` stay 0.
- R7: When both requests are present at one boundary, the non-maskable one is served. Its pending flag is cleared, so the next boundary serves the maskable request if it is still present.
- R8: Holding `nmi_i` high produces exactly one take. Further boundaries with no new rising edge give `take_o`=0.
- R9: `take_o` is high only in the cycle right after a cycle in which `boundary_i` was high. A latched request waits without a take for as long as no boundary comes.
- R10: `stall_o` equals `wait_i` AND the synchronized `test_i`. A low test level lets the wait instruction complete with `stall_o`=0.
- R11: A qualified internal reset clears the pending non-maskable flag and holds `take_o` low. A request latched before the reset is not served after it.
- R12: `take_o` is a single-cycle pulse per boundary decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, rising edge active |
| rst_raw_i | input | 1 | Asynchronous reset pin, active high |
| intr_i | input | 1 | Asynchronous maskable request, level, active high |
| nmi_i | input | 1 | Asynchronous non-maskable request, rising edge |
| test_i | input | 1 | Asynchronous test level examined by the wait instruction |
| ie_i | input | 1 | Software interrupt-enable flag |
| boundary_i | input | 1 | Sequencer marks the last clock of an instruction |
| wait_i | input | 1 | Sequencer is executing a wait instruction |
| core_rst_o | output | 1 | Qualified internal reset |
| take_o | output | 1 | One-cycle request to enter the interrupt sequence |
| ack_req_o | output | 1 | The take needs an external acknowledge cycle for its vector |
| vec_o | output | VEC_W | Vector type for a non-maskable take (2), else 0 |
| stall_o | output | 1 | Hold the core in the wait instruction |

## Verification
The assertions assume that `boundary_i` and `ie_i` come from the core's own clock domain and are stable around the rising edge. They also assume that `boundary_i` is never asserted in the cycle of a take, so that each decision can be matched to a single boundary. The bench drives every input on the falling edge. It changes the asynchronous pins only several clocks before the boundary that should see them, which keeps the synchronizer latency out of the expected results. The reset-filter property looks at the raw pin six clocks back, so it is armed only after the first qualified reset. The bench therefore issues the power-on reset before any other stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int VEC_W   = 8;
    localparam int NMI_VEC = 2;

    typedef enum logic [1:0] {
        RQ_IDLE  = 2'd0,
        RQ_COUNT = 2'd1,
        RQ_HOLD  = 2'd2
    } rq_state_t;

    typedef enum logic [1:0] {
        ARB_RUN  = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_NMI  = 2'd2,
        ARB_INT  = 2'd3
    } arb_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) chain[s] <= d_i;
            end else begin : g_next
                always_ff @(posedge clk_i) chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/irq_rst_qual.sv
module irq_rst_qual
    import irq_pkg::*;
#(
    parameter int MIN_RST = 4
) (
    input  logic clk_i,
    input  logic rst_s_i,
    output logic core_rst_o
);
    localparam int CW = $clog2(MIN_RST + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_RST - 1);

    rq_state_t   state, nxt;
    logic [CW-1:0] cnt;

    // state register and high-sample counter
    always_ff @(posedge clk_i) begin
        state <= nxt;
        if (!rst_s_i)
            cnt <= '0;
        else if (state == RQ_IDLE)
            cnt <= CW'(1);
        else if (state == RQ_COUNT)
            cnt <= cnt + CW'(1);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RQ_IDLE:  nxt = rst_s_i ? ((MIN_RST <= 1) ? RQ_HOLD : RQ_COUNT) : RQ_IDLE;
            RQ_COUNT: begin
                if (!rst_s_i)          nxt = RQ_IDLE;
                else if (cnt == LAST)  nxt = RQ_HOLD;
                else                   nxt = RQ_COUNT;
            end
            RQ_HOLD:  nxt = rst_s_i ? RQ_HOLD : RQ_IDLE;
            default:  nxt = RQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        core_rst_o = (state == RQ_HOLD);
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             intr_s_i,
    input  logic             nmi_s_i,
    input  logic             test_s_i,
    input  logic             ie_i,
    input  logic             boundary_i,
    input  logic             wait_i,
    output logic             take_o,
    output logic             ack_req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             stall_o
);
    arb_state_t state, nxt;
    logic       nmi_q;
    logic       nmi_pend;
    logic       nmi_edge;

    assign nmi_edge = nmi_s_i && !nmi_q;

    // state register
    always_ff @(posedge clk_i) begin
        if (clr_i) state <= ARB_RUN;
        else       state <= nxt;
    end

    // edge latch; the previous-level flop keeps tracking during reset
    always_ff @(posedge clk_i) begin
        nmi_q <= nmi_s_i;
        if (clr_i)
            nmi_pend <= 1'b0;
        else
            nmi_pend <= (nmi_pend && (state != ARB_NMI)) || nmi_edge;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ARB_RUN: begin
                if (boundary_i && nmi_pend)               nxt = ARB_NMI;
                else if (boundary_i && intr_s_i && ie_i)  nxt = ARB_INT;
                else if (wait_i && test_s_i)              nxt = ARB_WAIT;
                else                                      nxt = ARB_RUN;
            end
            ARB_WAIT: nxt = (wait_i && test_s_i) ? ARB_WAIT : ARB_RUN;
            ARB_NMI:  nxt = ARB_RUN;
            ARB_INT:  nxt = ARB_RUN;
            default:  nxt = ARB_RUN;
        endcase
    end

    // outputs
    always_comb begin
        take_o    = 1'b0;
        ack_req_o = 1'b0;
        vec_o     = '0;
        stall_o   = wait_i && test_s_i;
        unique case (state)
            ARB_NMI: begin
                take_o = 1'b1;
                vec_o  = VEC_W'(NMI_VEC);
            end
            ARB_INT: begin
                take_o    = 1'b1;
                ack_req_o = 1'b1;
            end
            ARB_RUN, ARB_WAIT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RST     = 4
) (
    input  logic             clk_i,
    input  logic             rst_raw_i,
    input  logic             intr_i,
    input  logic             nmi_i,
    input  logic             test_i,
    input  logic             ie_i,
    input  logic             boundary_i,
    input  logic             wait_i,
    output logic             core_rst_o,
    output logic             take_o,
    output logic             ack_req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             stall_o
);
    localparam int NPIN = 4;

    logic [NPIN-1:0] pins_s;

    irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .d_i   ({rst_raw_i, test_i, nmi_i, intr_i}),
        .q_o   (pins_s)
    );

    irq_rst_qual #(.MIN_RST(MIN_RST)) u_rq (
        .clk_i      (clk_i),
        .rst_s_i    (pins_s[3]),
        .core_rst_o (core_rst_o)
    );

    irq_arbiter u_arb (
        .clk_i      (clk_i),
        .clr_i      (core_rst_o),
        .intr_s_i   (pins_s[0]),
        .nmi_s_i    (pins_s[1]),
        .test_s_i   (pins_s[2]),
        .ie_i       (ie_i),
        .boundary_i (boundary_i),
        .wait_i     (wait_i),
        .take_o     (take_o),
        .ack_req_o  (ack_req_o),
        .vec_o      (vec_o),
        .stall_o    (stall_o)
    );
endmodule

// File: rtl/irq_ctl_unit_chk.sv
module irq_ctl_unit_chk
    import irq_pkg::*;
(
    input logic             clk_i,
    input logic             rst_raw_i,
    input logic             ie_i,
    input logic             boundary_i,
    input logic             wait_i,
    input logic             core_rst_o,
    input logic             take_o,
    input logic             ack_req_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             stall_o
);
    logic armed = 1'b0;
    always_ff @(posedge clk_i) if (core_rst_o) armed <= 1'b1;

    // R1
    rst_width_chk: assert property (@(posedge clk_i) disable iff (!armed)
        $rose(core_rst_o) |-> ($past(rst_raw_i, 3) && $past(rst_raw_i, 6)));

    // R12
    take_pulse_chk: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
        take_o |=> !take_o);

    // R9
    take_after_boundary_chk: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
        take_o |-> $past(boundary_i));

    // R6
    ack_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
        ack_req_o |-> ($past(ie_i) && take_o));

    // R3
    nmi_vector_chk: assert property (@(posedge clk_i) disable iff (!armed || core_rst_o)
        (take_o && !ack_req_o) |-> (vec_o == VEC_W'(NMI_VEC)));

    // R10
    stall_in_wait_chk: assert property (@(posedge clk_i) disable iff (!armed)
        stall_o |-> wait_i);

    // R11
    quiet_in_reset_chk: assert property (@(posedge clk_i) disable iff (!armed)
        ($past(core_rst_o) && core_rst_o) |-> !take_o);
endmodule

bind irq_ctl_unit irq_ctl_unit_chk u_chk (
    .clk_i      (clk_i),
    .rst_raw_i  (rst_raw_i),
    .ie_i       (ie_i),
    .boundary_i (boundary_i),
    .wait_i     (wait_i),
    .core_rst_o (core_rst_o),
    .take_o     (take_o),
    .ack_req_o  (ack_req_o),
    .vec_o      (vec_o),
    .stall_o    (stall_o)
);

// File: tb/tb_irq_ctl_unit.sv
module tb_irq_ctl_unit;
    import irq_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_raw = 1'b0, intr = 1'b0, nmi = 1'b0, test = 1'b0;
    logic ie = 1'b0, boundary = 1'b0, wt = 1'b0;
    logic core_rst, take, ack_req, stall;
    logic [VEC_W-1:0] vec;

    irq_ctl_unit dut (
        .clk_i(clk), .rst_raw_i(rst_raw), .intr_i(intr), .nmi_i(nmi),
        .test_i(test), .ie_i(ie), .boundary_i(boundary), .wait_i(wt),
        .core_rst_o(core_rst), .take_o(take), .ack_req_o(ack_req),
        .vec_o(vec), .stall_o(stall)
    );

    typedef struct {
        logic             take;
        logic             ack;
        logic [VEC_W-1:0] vec;
        string            tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // scoreboard monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " take"}, int'(take), int'(e.take));
                check({e.tag, " ack"},  int'(ack_req), int'(e.ack));
                check({e.tag, " vec"},  int'(vec), int'(e.vec));
            end
        end
    endtask_dummy: begin end
    end

    task automatic push(input logic t, input logic a, input int v, input string tag);
        exp_t e;
        e.take = t; e.ack = a; e.vec = VEC_W'(v); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one boundary cycle; expectation for the cycle after, then a quiet cycle (R12)
    task automatic boundary_hit(input logic t, input logic a, input int v, input string tag);
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
        push(t, a, v, tag);
        @(negedge clk);
        push(1'b0, 1'b0, 0, "R12 pulse end");
    endtask

    task automatic rst_pulse(input int n, input bit expect_hit, input string tag);
        bit seen = 1'b0;
        @(negedge clk) rst_raw = 1'b1;
        repeat (n) begin
            @(negedge clk);
            #1 if (core_rst) seen = 1'b1;
        end
        rst_raw = 1'b0;
        repeat (12) begin
            @(negedge clk);
            #1 if (core_rst) seen = 1'b1;
        end
        check(tag, int'(seen), int'(expect_hit));
        check("R2 reset released", int'(core_rst), 0);
    endtask

    initial begin
        // power-on reset, long enough to qualify
        rst_pulse(8, 1'b1, "R1 long pulse accepted");
        check("R11 no take after reset", int'(take), 0);
        check("R10 no stall at rest", int'(stall), 0);

        // R5 maskable request with enable set
        ie = 1'b1; intr = 1'b1; cycles(4);
        boundary_hit(1'b1, 1'b1, 0, "R5 intr taken");

        // R6 masked
        ie = 1'b0; cycles(2);
        boundary_hit(1'b0, 1'b0, 0, "R6 intr masked");
        intr = 1'b0;

        // R3 / R4 non-maskable with enable cleared
        @(negedge clk) nmi = 1'b1; cycles(4);
        boundary_hit(1'b1, 1'b0, NMI_VEC, "R3 R4 nmi taken");

        // R8 held high: no second take
        boundary_hit(1'b0, 1'b0, 0, "R8 no retrigger");
        @(negedge clk) nmi = 1'b0; cycles(4);

        // R9 no boundary: request waits
        @(negedge clk) nmi = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1 check("R9 no take without boundary", int'(take), 0);
        end
        boundary_hit(1'b1, 1'b0, NMI_VEC, "R9 late nmi taken");
        @(negedge clk) nmi = 1'b0; cycles(4);

        // R7 priority then maskable on next boundary
        ie = 1'b1; intr = 1'b1;
        @(negedge clk) nmi = 1'b1; cycles(4);
        boundary_hit(1'b1, 1'b0, NMI_VEC, "R7 nmi wins");
        boundary_hit(1'b1, 1'b1, 0, "R7 intr next");
        intr = 1'b0; ie = 1'b0;
        @(negedge clk) nmi = 1'b0; cycles(4);

        // R10 wait instruction
        @(negedge clk) begin wt = 1'b1; test = 1'b1; end
        cycles(3);
        #1 check("R10 stall while test high", int'(stall), 1);
        @(negedge clk) test = 1'b0;
        cycles(3);
        #1 check("R10 continue on test low", int'(stall), 0);
        @(negedge clk) wt = 1'b0;
        cycles(1);
        #1 check("R10 no stall outside wait", int'(stall), 0);

        // R1 short pulses ignored
        rst_pulse(3, 1'b0, "R1 3-cycle pulse ignored");
        rst_pulse(1, 1'b0, "R1 1-cycle pulse ignored");
        rst_pulse(4, 1'b1, "R1 4-cycle pulse accepted");

        // R11 reset clears pending non-maskable request
        @(negedge clk) nmi = 1'b1; cycles(4);
        rst_pulse(6, 1'b1, "R11 reset qualified");
        boundary_hit(1'b0, 1'b0, 0, "R11 pending cleared");
        @(negedge clk) nmi = 1'b0;
        cycles(4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule